// File: doc/BRIEF.md
# Registered Four-Function Arithmetic Unit

This block is a small arithmetic unit built around registers. Two operand registers are written through their own load strobes. When a start strobe arrives, four function circuits work on the held operand values at the same time: an adder, a subtractor, a magnitude comparator and a multiplier. A 2-bit opcode steers a selector that keeps one of those outputs.

An arithmetic outcome goes into the result register. A compare instead writes a three-bit relation register and leaves the result register as it was. A done pulse marks the cycle in which the new value is visible.

A controller loads the operands, then raises start for one cycle with the opcode. It reads the result or the relation flags while done is high, or at any later time until the next start.

Top module: `mux_alu`

## Requirements
- R1: After synchronous reset, both operand registers, the result register and the relation flags are zero, and done is low.
- R2: Opcode 2'b00 writes (A + B) modulo 2^W into the result register.
- R3: Opcode 2'b01 writes (A - B) modulo 2^W into the result register.
- R4: Opcode 2'b11 writes the low W bits of the product A * B into the result register.
- R5: Opcode 2'b10 compares A and B as unsigned numbers and writes the flags with exactly one bit set: bit 2 when A < B, bit 1 when A == B, bit 0 when A > B. The result register keeps its value.
- R6: An add, subtract or multiply leaves the relation flags unchanged.
- R7: The result or flags change in the cycle after start is sampled, and done is high for exactly that one cycle. Without start, the result and flags do not change.
- R8: An operand register takes its input on a clock edge where its load strobe is high. A start sampled on the same edge as a load works on the value held before that load.
- R9: Loading operands does not change the result register, the flags or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a | input | 1 | Write a_in into operand register A |
| ld_b | input | 1 | Write b_in into operand register B |
| a_in | input | W | Data for operand A |
| b_in | input | W | Data for operand B |
| op_sel | input | 2 | Function select: 00 add, 01 subtract, 10 compare, 11 multiply |
| start | input | 1 | Run the selected function on the held operands |
| result | output | W | Result register |
| cmp_flags | output | 3 | Relation flags: bit 2 less, bit 1 equal, bit 0 greater |
| done | output | 1 | High for the one cycle in which a new result or new flags appear |

## Verification
An operand load and a start can fall on the same clock edge. This tests whether the functions read the registered operands or the incoming data. The bench provokes it by loading known operands and then raising start together with a new load of A. It expects the outcome computed from the old value, and then the new value on a following start. Random sequences of loads and operations, with bench functions as reference, also check that each opcode touches only its own destination register.

// File: rtl/mux_alu_pkg.sv
package mux_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_MUL = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_flags_t;

    localparam int unsigned REL_W   = $bits(rel_flags_t);
    localparam int unsigned N_OPND  = 2;
    localparam rel_flags_t  REL_CLR = '{lt: 1'b0, eq: 1'b0, gt: 1'b0};

    function automatic logic writes_flags(input alu_op_e op);
        return op == OP_CMP;
    endfunction

endpackage

// File: rtl/alu_opnd_reg.sv
module alu_opnd_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_func_units.sv
module alu_func_units
    import mux_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic [W-1:0] prod,
    output rel_flags_t   rel
);

    // All circuits evaluate on every cycle; the selector picks one later.
    always_comb begin
        sum    = opa + opb;
        diff   = opa - opb;
        prod   = opa * opb;
        rel.lt = opa < opb;
        rel.eq = opa == opb;
        rel.gt = opa > opb;
    end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
    import mux_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  alu_op_e      op,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] diff,
    input  logic [W-1:0] prod,
    input  rel_flags_t   rel,
    output logic [W-1:0] result,
    output rel_flags_t   flags,
    output logic         done
);

    logic [W-1:0] picked;
    logic         to_flags;

    always_comb begin
        unique case (op)
            OP_ADD:  picked = sum;
            OP_SUB:  picked = diff;
            OP_MUL:  picked = prod;
            default: picked = result;
        endcase
        to_flags = writes_flags(op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            flags  <= REL_CLR;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                if (to_flags) begin
                    flags <= rel;
                end else begin
                    result <= picked;
                end
            end
        end
    end

endmodule

// File: rtl/mux_alu.sv
module mux_alu
    import mux_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_a,
    input  logic             ld_b,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    input  logic [1:0]       op_sel,
    input  logic             start,
    output logic [W-1:0]     result,
    output logic [REL_W-1:0] cmp_flags,
    output logic             done
);

    logic [W-1:0] opnd_d [N_OPND];
    logic [W-1:0] opnd_q [N_OPND];
    logic         opnd_ld[N_OPND];

    logic [W-1:0] sum_w, diff_w, prod_w;
    rel_flags_t   rel_w, flags_q;

    always_comb begin
        opnd_d[0]  = a_in;
        opnd_d[1]  = b_in;
        opnd_ld[0] = ld_a;
        opnd_ld[1] = ld_b;
    end

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        alu_opnd_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (opnd_ld[i]),
            .d    (opnd_d[i]),
            .q    (opnd_q[i])
        );
    end

    alu_func_units #(.W(W)) u_units (
        .opa  (opnd_q[0]),
        .opb  (opnd_q[1]),
        .sum  (sum_w),
        .diff (diff_w),
        .prod (prod_w),
        .rel  (rel_w)
    );

    alu_out_stage #(.W(W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (alu_op_e'(op_sel)),
        .sum    (sum_w),
        .diff   (diff_w),
        .prod   (prod_w),
        .rel    (rel_w),
        .result (result),
        .flags  (flags_q),
        .done   (done)
    );

    assign cmp_flags = flags_q;

endmodule

// File: rtl/mux_alu_chk.sv
module mux_alu_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic [2:0]   cmp_flags,
    input logic         done
);

    // R7: done follows start by one cycle
    a_r7_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R7: done and outputs stay still without start
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && $stable(result) && $stable(cmp_flags)));

    // R5: a compare sets exactly one flag and keeps the result
    a_r5_cmp_one_flag: assert property (@(posedge clk) disable iff (rst)
        (start && op_sel == 2'b10) |=> ($countones(cmp_flags) == 1 && $stable(result)));

    // R6: arithmetic keeps the flags
    a_r6_arith_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (start && op_sel != 2'b10) |=> $stable(cmp_flags));

    // R5: flags are never more than one-hot
    a_r5_flags_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmp_flags));

endmodule

bind mux_alu mux_alu_chk #(.W(W)) u_mux_alu_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_sel    (op_sel),
    .result    (result),
    .cmp_flags (cmp_flags),
    .done      (done)
);

// File: tb/test_mux_alu.sv
module test_mux_alu;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_a = 1'b0, ld_b = 1'b0, start = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] result;
    logic [2:0]   cmp_flags;
    logic         done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [W-1:0] m_a = '0, m_b = '0, m_res = '0;
    logic [2:0]   m_flags = '0;

    mux_alu #(.W(W)) i_mux_alu (
        .clk(clk), .rst(rst), .ld_a(ld_a), .ld_b(ld_b), .a_in(a_in), .b_in(b_in),
        .op_sel(op_sel), .start(start), .result(result), .cmp_flags(cmp_flags), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] exp_arith(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] full;
        full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        case (op)
            2'b00:   return W'(({1'b0, a} + {1'b0, b}) % (1 << W));
            2'b01:   return W'(((1 << W) + int'(a) - int'(b)) % (1 << W));
            default: return full[W-1:0];
        endcase
    endfunction

    function automatic logic [2:0] exp_rel(input logic [W-1:0] a, input logic [W-1:0] b);
        if (a < b)  return 3'b100;
        if (a == b) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
        ld_a = 1'b1; ld_b = 1'b1; a_in = a; b_in = b;
        tick();
        ld_a = 1'b0; ld_b = 1'b0;
        m_a = a; m_b = b;
        chk("R9 result after load", int'(result), int'(m_res));
        chk("R9 flags after load", int'(cmp_flags), int'(m_flags));
        chk("R9 done after load", int'(done), 0);
    endtask

    task automatic check_op(input logic [1:0] op);
        if (op == 2'b10) begin
            m_flags = exp_rel(m_a, m_b);
            chk("R5 compare flags", int'(cmp_flags), int'(m_flags));
            chk("R5 compare keeps result", int'(result), int'(m_res));
        end else begin
            m_res = exp_arith(op, m_a, m_b);
            case (op)
                2'b00:   chk("R2 add result", int'(result), int'(m_res));
                2'b01:   chk("R3 subtract result", int'(result), int'(m_res));
                default: chk("R4 multiply result", int'(result), int'(m_res));
            endcase
            chk("R6 arithmetic keeps flags", int'(cmp_flags), int'(m_flags));
        end
        chk("R7 done pulse", int'(done), 1);
    endtask

    task automatic run(input logic [1:0] op);
        start = 1'b1; op_sel = op;
        tick();
        start = 1'b0;
        check_op(op);
        tick();
        chk("R7 done one cycle", int'(done), 0);
        chk("R7 result held", int'(result), int'(m_res));
        chk("R7 flags held", int'(cmp_flags), int'(m_flags));
    endtask

    initial begin
        #(20 * 200000);
        if (!ended) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 result reset", int'(result), 0);
        chk("R1 flags reset", int'(cmp_flags), 0);
        chk("R1 done reset", int'(done), 0);
        // R1 operand registers cleared: compare of zero operands gives equal
        run(2'b10);

        load(8'd200, 8'd100); run(2'b00);      // R2 wrap to 44
        load(8'd5,   8'd10);  run(2'b01);      // R3 wrap to 251
        load(8'd20,  8'd20);  run(2'b11);      // R4 400 -> 144
        run(2'b10);                            // R5 equal
        load(8'd255, 8'd255); run(2'b11);      // R4 low byte 1
        load(8'd3,   8'd250); run(2'b10);      // R5 less
        load(8'd250, 8'd3);   run(2'b10);      // R5 greater
        load(8'd0,   8'd1);   run(2'b01);      // R3 0-1 = 255

        // R8: start on the same edge as a load of A uses the old A
        load(8'd10, 8'd3);
        ld_a = 1'b1; a_in = 8'd200; start = 1'b1; op_sel = 2'b00;
        tick();
        ld_a = 1'b0; start = 1'b0;
        chk("R8 start with load uses old operand", int'(result), 13);
        m_res = 8'd13; m_a = 8'd200;
        tick();
        run(2'b00);
        chk("R8 new operand after load", int'(result), 203);

        for (int i = 0; i < 150; i++) begin
            load(W'($urandom), W'($urandom));
            run(2'($urandom));
        end

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule